// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a register-mapped general-purpose I/O controller for a parameterised number of pins, always a whole number of 32-pin banks (64 and 96 pins are the intended sizes). A host reaches it through a plain word interface with an address, write data, a write strobe, a read strobe and a read-data return. Toward the pads it drives an output value bus and an output-enable bus, and it samples an input bus. Each pin can be read back, turned into an output or an input, and driven high or low through dedicated write-one set and clear words, so no read-modify-write is needed to change one pin.

Inputs are first resynchronised. The synchronised pin value is then compared with its value one cycle earlier to find rising and falling transitions. Each direction is qualified by its own per-pin enable. A qualified transition sets a sticky status bit, which stays set until software writes a one to it. A single interrupt line is high whenever any status bit in any bank is set.

Registers are grouped by feature, and each feature spans one 32-bit word per bank. Software locates a pin's bit from the feature number, the bank number and the pin's position within its bank.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, the direction, output, rising-enable, falling-enable and status state are all zero, so `pin_oe`, `pin_out` and `irq` are low and those words read as zero.
- R2: The word address is `addr[ADDR_W-1:2]`. Feature f, bank b sits at word f*NBANK+b, where NBANK = NPINS/32, and pin p is bit p%32 of bank p/32. The feature numbers are: 0 level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 edge status.
- R3: A write to a direction word replaces that bank's 32 direction bits. `pin_oe` follows them one cycle later, with 1 meaning output and 0 meaning input.
- R4: Writing to a set word forces `pin_out` high for every bit written as 1, from the next cycle on. Bits written as 0 and other banks keep their values.
- R5: Writing to a clear word forces `pin_out` low for every bit written as 1, from the next cycle on. Bits written as 0 and other banks keep their values. The set and clear words read as zero.
- R6: A level word returns the pin inputs after a two-flop synchronizer. A change on `pin_in` becomes visible on the second clock edge after it. Writes to level words change nothing.
- R7: With its rising enable set, a pin whose synchronised value goes from 0 to 1 sets its status bit on the following clock edge.
- R8: With its falling enable set, a pin whose synchronised value goes from 1 to 0 sets its status bit. With both enables set, both kinds of edge are recorded. With neither set, no edge is recorded.
- R9: Writing 1 to a status bit clears it. Bits written as 0 keep their state.
- R10: If a qualifying edge and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq` is high exactly when at least one status bit in any bank is set.
- R12: Reads from word addresses at or above 7*NBANK return zero, and writes to them change no state.
- R13: `rd_data` is zero whenever `rd_en` is low. Reads are combinational on the current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the accessed word |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, zero when not reading |
| pin_in | input | NPINS | Pad input values |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| irq | output | 1 | OR of all edge status bits |

## Verification
The hardest case to reach from the ports is a new edge landing in exactly the cycle in which software writes a one to clear the same status bit. The edge only reaches the status logic after the synchronizer and the previous-value stage. The stimulus therefore toggles a pad and issues the clearing write at several fixed offsets afterwards, one of which is the exact collision cycle. A directed case also counts the register stages to hit that cycle on purpose. Edges caused by the block's own outputs are reached by feeding the output bus back onto the input bus for pins set as outputs, so a set write turns into a captured rising edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Width of one register word and of one pin bank
    localparam int unsigned BANK_W   = 32;
    // Number of feature groups in the register map
    localparam int unsigned NUM_FEAT = 7;

    // Feature order fixes the word layout: feature f, bank b -> word f*NBANK+b
    typedef enum logic [2:0] {
        FT_LEVEL = 3'd0,
        FT_DIR   = 3'd1,
        FT_SET   = 3'd2,
        FT_CLR   = 3'd3,
        FT_RISE  = 3'd4,
        FT_FALL  = 3'd5,
        FT_STAT  = 3'd6
    } feat_e;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int unsigned W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NBANK  = 2,
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic [NUM_FEAT*NBANK-1:0] word_sel,
    output logic                      map_hit
);

    localparam int unsigned NWORD = NUM_FEAT * NBANK;

    logic [ADDR_W-3:0] word_idx;
    logic [1:0]        unused_byte_lane;

    assign word_idx         = addr[ADDR_W-1:2];
    assign unused_byte_lane = addr[1:0];

    always_comb begin
        for (int i = 0; i < NWORD; i++) begin
            word_sel[i] = (int'(word_idx) == i);
        end
        map_hit = |word_sel;
    end

endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    output logic [W-1:0] hit
);

    logic [W-1:0] went_up;
    logic [W-1:0] went_down;

    always_comb begin
        went_up   = cur & ~prev;
        went_down = ~cur & prev;
        hit       = (went_up & rise_en) | (went_down & fall_en);
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 64,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    localparam int unsigned NBANK = NPINS / BANK_W;
    localparam int unsigned NWORD = NUM_FEAT * NBANK;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] out;
        logic [NPINS-1:0] rise_en;
        logic [NPINS-1:0] fall_en;
        logic [NPINS-1:0] status;
        logic [NPINS-1:0] prev;
    } regs_t;

    regs_t state_d, state_q;

    // Synchronised pad values
    logic [NPINS-1:0] pin_sync;

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    // Word decode
    logic [NWORD-1:0] word_sel;
    logic             map_hit;

    gpio_addr_dec #(.NBANK(NBANK), .ADDR_W(ADDR_W)) u_dec (
        .addr     (addr),
        .word_sel (word_sel),
        .map_hit  (map_hit)
    );

    // Edge qualification against the previous synchronised value
    logic [NPINS-1:0] edge_hit;

    gpio_edge_unit #(.W(NPINS)) u_edge (
        .cur     (pin_sync),
        .prev    (state_q.prev),
        .rise_en (state_q.rise_en),
        .fall_en (state_q.fall_en),
        .hit     (edge_hit)
    );

    // Per-feature write masks, expanded to full pin width (level is never written)
    logic [NUM_FEAT-1:1][NPINS-1:0] wsel;
    logic [NPINS-1:0]               wdat;

    assign wdat = {NBANK{wr_data}};

    for (genvar f = 1; f < NUM_FEAT; f++) begin : g_feat
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            assign wsel[f][b*BANK_W +: BANK_W] = {BANK_W{wr_en & word_sel[f*NBANK+b]}};
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;

        state_d.dir     = (state_q.dir     & ~wsel[FT_DIR])  | (wdat & wsel[FT_DIR]);
        state_d.rise_en = (state_q.rise_en & ~wsel[FT_RISE]) | (wdat & wsel[FT_RISE]);
        state_d.fall_en = (state_q.fall_en & ~wsel[FT_FALL]) | (wdat & wsel[FT_FALL]);

        state_d.out = (state_q.out | (wdat & wsel[FT_SET])) & ~(wdat & wsel[FT_CLR]);

        // Clear first, then capture: a same-cycle edge survives the clear
        state_d.status = (state_q.status & ~(wdat & wsel[FT_STAT])) | edge_hit;

        state_d.prev = pin_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    // Read path
    logic [NUM_FEAT-1:0][NPINS-1:0] feat_rd;
    logic [31:0]                    rd_mux;

    always_comb begin
        feat_rd[FT_LEVEL] = pin_sync;
        feat_rd[FT_DIR]   = state_q.dir;
        feat_rd[FT_SET]   = '0;
        feat_rd[FT_CLR]   = '0;
        feat_rd[FT_RISE]  = state_q.rise_en;
        feat_rd[FT_FALL]  = state_q.fall_en;
        feat_rd[FT_STAT]  = state_q.status;

        rd_mux = '0;
        for (int i = 0; i < NWORD; i++) begin
            if (word_sel[i]) begin
                rd_mux = rd_mux | feat_rd[i / NBANK][(i % NBANK)*BANK_W +: BANK_W];
            end
        end
    end

    assign rd_data = (rd_en && map_hit) ? rd_mux : '0;
    assign pin_out = state_q.out;
    assign pin_oe  = state_q.dir;
    assign irq     = |state_q.status;

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS  = 64,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wr_data,
    input logic              wr_en,
    input logic              rd_en,
    input logic [31:0]       rd_data,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic              irq
);

    localparam int unsigned NBANK   = NPINS / BANK_W;
    localparam int unsigned DIR_A0  = 1 * NBANK * 4;
    localparam int unsigned SET_A0  = 2 * NBANK * 4;
    localparam int unsigned CLR_A0  = 3 * NBANK * 4;
    localparam int unsigned LVL_END = NBANK * 4;
    localparam int unsigned MAP_END = NUM_FEAT * NBANK * 4;

    logic in_rst_q;

    always_ff @(posedge clk) begin
        // R1
        if (rst_n && in_rst_q) begin
            reset_clean_chk: assert (pin_oe == '0 && pin_out == '0 && !irq);
        end
        in_rst_q <= !rst_n;
    end

    // R3
    dir_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == DIR_A0) |=> (pin_oe[31:0] == $past(wr_data)));

    // R4
    set_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == SET_A0) |=> ((pin_out[31:0] & $past(wr_data)) == $past(wr_data)));

    // R5
    clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) == CLR_A0) |=> ((pin_out[31:0] & $past(wr_data)) == 32'd0));

    // R6
    level_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) < LVL_END) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R12
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(addr) >= MAP_END) |-> (rd_data == 32'd0));

    // R13
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en) |-> (rd_data == 32'd0));

endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .irq     (irq)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_tb_top;

    localparam int NP = 64;
    localparam int NB = NP / 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wr_data = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;
    logic [NP-1:0] ext = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    // Pads: outputs loop back, inputs come from the bench
    assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

    gpio_bank_ctrl #(.NPINS(NP), .ADDR_W(8)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_data (wr_data),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq     (irq)
    );

    // ---------------- reference model ----------------
    logic [NP-1:0] m_dir, m_out, m_re, m_fe, m_st;
    logic [NP-1:0] hist[$];

    initial begin
        m_dir = '0; m_out = '0; m_re = '0; m_fe = '0; m_st = '0;
        hist = '{'0, '0, '0};
    end

    function automatic logic [NP-1:0] place(input logic [31:0] w, input int b);
        logic [NP-1:0] v;
        v = '0;
        v[b*32 +: 32] = w;
        return v;
    endfunction

    function automatic logic [31:0] mread(input logic [7:0] a);
        int wi, f, b;
        logic [NP-1:0] v;
        wi = int'(a) / 4;
        if (wi >= 7 * NB) return 32'd0;
        f = wi / NB;
        b = wi % NB;
        case (f)
            0: v = hist[1];
            1: v = m_dir;
            4: v = m_re;
            5: v = m_fe;
            6: v = m_st;
            default: v = '0;
        endcase
        return v[b*32 +: 32];
    endfunction

    always @(posedge clk) begin
        logic [NP-1:0] pinv, up, dn, mask;
        int wi, f, b;
        if (!rst_n) begin
            m_dir = '0; m_out = '0; m_re = '0; m_fe = '0; m_st = '0;
            hist = '{'0, '0, '0};
        end else begin
            pinv = (m_dir & m_out) | (~m_dir & ext);
            up   = hist[1] & ~hist[2];
            dn   = ~hist[1] & hist[2];
            mask = '0;
            f = -1; b = 0;
            wi = int'(addr) / 4;
            if (wr_en && wi < 7 * NB) begin
                f = wi / NB;
                b = wi % NB;
                mask = place(32'hFFFF_FFFF, b);
            end
            m_st = (m_st & ~((f == 6) ? place(wr_data, b) : '0)) | (up & m_re) | (dn & m_fe);
            if (f == 1) m_dir = (m_dir & ~mask) | place(wr_data, b);
            if (f == 2) m_out = m_out | place(wr_data, b);
            if (f == 3) m_out = m_out & ~place(wr_data, b);
            if (f == 4) m_re = (m_re & ~mask) | place(wr_data, b);
            if (f == 5) m_fe = (m_fe & ~mask) | place(wr_data, b);
            hist.push_front(pinv);
            void'(hist.pop_back());
        end
    end

    // ---------------- every-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (pin_out !== m_out) begin
                fails++;
                $display("FAIL R4 R5 pin_out actual=%h expected=%h", pin_out, m_out);
            end
            checks++;
            if (pin_oe !== m_dir) begin
                fails++;
                $display("FAIL R3 pin_oe actual=%h expected=%h", pin_oe, m_dir);
            end
            checks++;
            if (irq !== (|m_st)) begin
                fails++;
                $display("FAIL R11 irq actual=%b expected=%b", irq, |m_st);
            end
            checks++;
            if (rd_en) begin
                if (rd_data !== mread(addr)) begin
                    fails++;
                    $display("FAIL R2 rd_data @%h actual=%h expected=%h", addr, rd_data, mread(addr));
                end
            end else if (rd_data !== 32'd0) begin
                fails++;
                $display("FAIL R13 idle rd_data actual=%h expected=0", rd_data);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #2;
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); #2;
        wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #2;
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s read @%h actual=%h expected=%h", tag, a, rd_data, exp);
        end
        #2 rd_en = 1'b0;
    endtask

    task automatic expect_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Byte addresses for NB banks: feature f, bank b -> (f*NB+b)*4
    function automatic logic [7:0] wa(input int f, input int b);
        return 8'((f * NB + b) * 4);
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                fails++;
                $display("FAIL watchdog expired");
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        idle(3);
        #2 rst_n = 1'b1;
        idle(1);

        // R1: reset state
        expect_bit(irq, 1'b0, "R1 irq");
        expect_rd(wa(1, 0), 32'd0, "R1 dir");
        expect_rd(wa(4, 1), 32'd0, "R1 rise");
        expect_rd(wa(6, 0), 32'd0, "R1 status");

        // R2/R3: direction word of bank 1
        wr(wa(1, 1), 32'hA5A5_0000);
        expect_rd(wa(1, 1), 32'hA5A5_0000, "R2 dir bank1");
        expect_bit(pin_oe[48], 1'b1, "R3 pin 48 output");
        expect_bit(pin_oe[32], 1'b0, "R3 pin 32 input");

        // R4/R5: set and clear words
        wr(wa(2, 0), 32'h0000_00F0);
        expect_bit(pin_out[7:4] == 4'hF, 1'b1, "R4 set bits");
        wr(wa(2, 0), 32'h0000_0001);
        expect_bit(pin_out[31:0] == 32'h0000_00F1, 1'b1, "R4 zeros untouched");
        wr(wa(3, 0), 32'h0000_0010);
        expect_bit(pin_out[31:0] == 32'h0000_00E1, 1'b1, "R5 clear bit");
        expect_rd(wa(3, 0), 32'd0, "R5 clear reads zero");

        // R6: level readback and ignored writes
        @(negedge clk); #2 ext[31:0] = 32'h1234_5678;
        idle(3);
        expect_rd(wa(0, 0), 32'h1234_5678, "R6 level");
        wr(wa(0, 0), 32'hFFFF_FFFF);
        expect_rd(wa(0, 0), 32'h1234_5678, "R6 level write ignored");
        expect_rd(wa(1, 1), 32'hA5A5_0000, "R6 dir unchanged");

        // R12: outside the map
        expect_rd(8'(7 * NB * 4), 32'd0, "R12 unmapped read");
        wr(8'(7 * NB * 4 + 4), 32'hFFFF_FFFF);
        expect_rd(wa(1, 0), 32'd0, "R12 unmapped write inert");

        // R7: rising edge on pin 0
        wr(wa(4, 0), 32'h0000_0001);
        wr(wa(5, 0), 32'h0000_0002);
        @(negedge clk); #2 ext[0] = 1'b1;
        idle(4);
        expect_rd(wa(6, 0), 32'h0000_0001, "R7 rising captured");
        expect_bit(irq, 1'b1, "R11 irq set");

        // R8: falling edge on pin 1 (rise on pin 1 not enabled)
        @(negedge clk); #2 ext[1] = 1'b1;
        idle(4);
        expect_rd(wa(6, 0), 32'h0000_0001, "R8 unqualified rise ignored");
        @(negedge clk); #2 ext[1] = 1'b0;
        idle(4);
        expect_rd(wa(6, 0), 32'h0000_0003, "R8 falling captured");

        // R9/R11: write-one-to-clear
        wr(wa(6, 0), 32'h0000_0000);
        expect_rd(wa(6, 0), 32'h0000_0003, "R9 zero write no effect");
        wr(wa(6, 0), 32'h0000_0001);
        expect_rd(wa(6, 0), 32'h0000_0002, "R9 one bit cleared");
        expect_bit(irq, 1'b1, "R11 irq still set");
        wr(wa(6, 0), 32'h0000_0002);
        expect_bit(irq, 1'b0, "R11 irq cleared");

        // R10: edge coincides with clear of the same bit
        @(negedge clk); #2 ext[0] = 1'b0;
        idle(4);
        @(negedge clk); #2 ext[0] = 1'b1;
        @(negedge clk);
        @(negedge clk); #2 addr = wa(6, 0); wr_data = 32'h0000_0001; wr_en = 1'b1;
        @(negedge clk); #2 wr_en = 1'b0;
        expect_rd(wa(6, 0), 32'h0000_0001, "R10 edge beats clear");
        wr(wa(6, 0), 32'hFFFF_FFFF);

        // R7: edge produced through output loopback on pin 48
        wr(wa(4, 1), 32'h0001_0000);
        wr(wa(2, 1), 32'h0001_0000);
        idle(4);
        expect_rd(wa(6, 1), 32'h0001_0000, "R7 loopback edge");
        wr(wa(6, 1), 32'hFFFF_FFFF);

        // R10: clearing writes at a range of offsets after an edge
        wr(wa(5, 0), 32'h0000_0100);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #2 ext[8] = ~ext[8];
            idle(k);
            wr(wa(6, 0), 32'h0000_0100);
            idle(3);
        end

        // Mixed traffic against the model
        for (int n = 0; n < 400; n++) begin
            @(negedge clk); #2;
            wr_en   = 1'b0;
            rd_en   = 1'b0;
            addr    = 8'($urandom_range(0, 63));
            wr_data = $urandom;
            case ($urandom_range(0, 3))
                0: wr_en = 1'b1;
                1: rd_en = 1'b1;
                2: ext = {$urandom, $urandom};
                default: ;
            endcase
        end
        @(negedge clk); #2 wr_en = 1'b0; rd_en = 1'b0;
        idle(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule